// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible front of a panel display controller. A small 32-bit register bus reaches six word registers: control, three timing words, a read-only status word and a subpanel word. The unit decodes the control word into enable, mono, TFT and palette-loading outputs. It turns the two size fields into panel width and height for the display datapath. Offsets outside the map read as zero and raise a bad-access flag for that cycle.

The datapath reports three events as one-cycle pulses: a frame finished, the palette was loaded, and a sync error. The unit keeps each event as a sticky status bit and combines the bits with a two-bit mask to drive one registered, level-sensitive interrupt line. A sync error always interrupts, whatever the mask holds.

A two-state machine follows the enable bit. In ST_OFF the panel is idle. The transition T_START (ST_OFF to ST_ON, enable written 1) clears the frame and palette status. The transition T_STOP (ST_ON to ST_OFF, enable written 0) clears the sync status and sets frame status, unless the palette-loading mode is 1. Writes that leave enable unchanged keep the state as it is (T_HOLD).

Top module: `lcd_regif`

## Requirements
- R1: After reset every output is low or zero. Reads then return control 0xfe000c34, timing0 0x000003ff, timing1 0x000003ff, timing2 0xfc000000, status 0 and subpanel 0.
- R2: A control write at offset 0x00 sets lcd_en from bit 0, mono_mode from bit 1, the interrupt mask from bits 4:3, tft_mode from bit 7 and pal_mode from bits 21:20. It also keeps the written bits under 0x01cff300 as spare control bits. Outputs change at the write edge.
- R3: A control read returns the spare bits ORed with the decoded fields, with tft placed at both bit 23 and bit 7, and with 0xfe000c34.
- R4: A write to timing0 at 0x04 sets panel_width to bits 9:0 plus one, so that 0x3ff gives 1024, and stores bits 31:10. The read returns the stored upper bits above (panel_width-1) in bits 9:0, with bits 3:0 forced to 1.
- R5: A write to timing1 at 0x08 sets panel_height to bits 9:0 plus one and stores bits 31:10. The read returns them in the same layout, with no forced bits.
- R6: Timing2 at 0x0c stores the whole written word and reads back ORed with 0xfc000000.
- R7: Subpanel at 0x14 stores the written word ANDed with 0xa1ffffff.
- R8: Status at 0x10 reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0. Writes to it change nothing. An event pulse sets its bit, and the bit stays set until an enable transition clears it.
- R9: irq equals (frame-done AND mask bit 0) OR (palette-done AND mask bit 1) OR sync-error. It is evaluated on the status and mask as they stood before the edge, so it follows them one cycle later. A sync error interrupts even when the mask is zero.
- R10: On T_STOP, sync-error is cleared and frame-done is set unless the pal_mode written with it is 1. An event pulse in the same cycle still sets its bit.
- R11: On T_START, frame-done and palette-done are cleared. An event pulse in the same cycle still sets its bit.
- R12: A selected access to an offset that is not word aligned or lies above 0x14 drives bad_access high in that cycle and bus_rdata to zero, and a write there changes nothing. bus_rdata is zero when bus_sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bad_access | output | 1 | Access to an unmapped offset |
| evt_frame | input | 1 | Frame-finished pulse |
| evt_pal | input | 1 | Palette-loaded pulse |
| evt_sync | input | 1 | Sync-error pulse |
| lcd_en | output | 1 | Panel enable |
| mono_mode | output | 1 | Monochrome mode |
| tft_mode | output | 1 | Active-matrix mode |
| pal_mode | output | 2 | Palette-loading mode |
| panel_width | output | SIZE_W+1 | Pixels per line |
| panel_height | output | SIZE_W+1 | Lines per frame |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: ADDR_W of 8 and SIZE_W of 10. With these values every offset from 0x00 to 0xff can be hit, so the seeded random traffic reaches the misaligned offsets and the gap above 0x14 as well as the six registers. The 10-bit size field lets the bench reach both size extremes, 1 and 1024. Random control writes toggle enable while events arrive, so T_START and T_STOP occur with and without a coincident event pulse, and with pal_mode both at 1 and at other values.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
    localparam int DATA_W = 32;
    localparam int NREG   = 6;

    localparam int IX_CTRL = 0;
    localparam int IX_TIM0 = 1;
    localparam int IX_TIM1 = 2;
    localparam int IX_TIM2 = 3;
    localparam int IX_STAT = 4;
    localparam int IX_SUBP = 5;

    localparam logic [DATA_W-1:0] CTRL_SPARE_MASK = 32'h01cf_f300;
    localparam logic [DATA_W-1:0] CTRL_RD_ONES    = 32'hfe00_0c34;
    localparam logic [DATA_W-1:0] TIM0_RD_ONES    = 32'h0000_000f;
    localparam logic [DATA_W-1:0] TIM2_RD_ONES    = 32'hfc00_0000;
    localparam logic [DATA_W-1:0] SUBP_KEEP_MASK  = 32'ha1ff_ffff;

    typedef enum logic { ST_OFF = 1'b0, ST_ON = 1'b1 } pstate_t;

    typedef struct packed {
        logic              en;
        logic              mono;
        logic [1:0]        mask;
        logic              tft;
        logic [1:0]        pal;
        logic [DATA_W-1:0] spare;
    } ctrl_t;
endpackage

// File: rtl/lcd_regif_dec.sv
module lcd_regif_dec
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NREG-1:0]   hit,
    output logic [NREG-1:0]   wr,
    output logic              bad
);
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = bus_sel && (bus_addr == ADDR_W'(i * 4));
        assign wr[i]  = hit[i] && bus_we;
    end

    assign bad = bus_sel && !(|hit);
endmodule

// File: rtl/lcd_regif_regs.sv
module lcd_regif_regs
    import lcd_regif_pkg::*;
#(
    parameter int SIZE_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          wr,
    input  logic [DATA_W-1:0]        wdata,
    output ctrl_t                    ctrl_q,
    output logic                     en_next,
    output logic [1:0]               pal_next,
    output logic [DATA_W-SIZE_W-1:0] t0_hi,
    output logic [DATA_W-SIZE_W-1:0] t1_hi,
    output logic [SIZE_W:0]          width_q,
    output logic [SIZE_W:0]          height_q,
    output logic [DATA_W-1:0]        t2_q,
    output logic [DATA_W-1:0]        subp_q
);
    localparam int HI_W = DATA_W - SIZE_W;

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr[IX_CTRL]) begin
            ctrl_d.en    = wdata[0];
            ctrl_d.mono  = wdata[1];
            ctrl_d.mask  = wdata[4:3];
            ctrl_d.tft   = wdata[7];
            ctrl_d.pal   = wdata[21:20];
            ctrl_d.spare = wdata & CTRL_SPARE_MASK;
        end
    end

    assign en_next  = ctrl_d.en;
    assign pal_next = ctrl_d.pal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            t0_hi    <= '0;
            t1_hi    <= '0;
            width_q  <= '0;
            height_q <= '0;
            t2_q     <= '0;
            subp_q   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr[IX_TIM0]) begin
                t0_hi   <= wdata[DATA_W-1:SIZE_W];
                width_q <= (SIZE_W+1)'(wdata[SIZE_W-1:0]) + (SIZE_W+1)'(1);
            end
            if (wr[IX_TIM1]) begin
                t1_hi    <= wdata[DATA_W-1:SIZE_W];
                height_q <= (SIZE_W+1)'(wdata[SIZE_W-1:0]) + (SIZE_W+1)'(1);
            end
            if (wr[IX_TIM2]) t2_q   <= wdata;
            if (wr[IX_SUBP]) subp_q <= wdata & SUBP_KEEP_MASK;
        end
    end

    logic [HI_W-1:0] unused_hi_chk;
    assign unused_hi_chk = '0;
endmodule

// File: rtl/lcd_regif_stat.sv
module lcd_regif_stat
    import lcd_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_next,
    input  logic [1:0] pal_next,
    input  logic [1:0] mask,
    input  logic       evt_frame,
    input  logic       evt_pal,
    input  logic       evt_sync,
    output logic       st_frame,
    output logic       st_pal,
    output logic       st_sync,
    output logic       irq
);
    pstate_t state_q, state_d;
    logic    f_d, p_d, s_d;

    always_comb begin
        state_d = en_next ? ST_ON : ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        f_d = st_frame;
        p_d = st_pal;
        s_d = st_sync;
        unique case (state_q)
            ST_OFF: begin
                if (state_d == ST_ON) begin
                    f_d = 1'b0;
                    p_d = 1'b0;
                end
            end
            ST_ON: begin
                if (state_d == ST_OFF) begin
                    s_d = 1'b0;
                    if (pal_next != 2'd1) f_d = 1'b1;
                end
            end
            default: ;
        endcase
        f_d = f_d | evt_frame;
        p_d = p_d | evt_pal;
        s_d = s_d | evt_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_frame <= 1'b0;
            st_pal   <= 1'b0;
            st_sync  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            st_frame <= f_d;
            st_pal   <= p_d;
            st_sync  <= s_d;
            irq      <= (st_frame && mask[0]) || (st_pal && mask[1]) || st_sync;
        end
    end
endmodule

// File: rtl/lcd_regif_rdmux.sv
module lcd_regif_rdmux
    import lcd_regif_pkg::*;
#(
    parameter int SIZE_W = 10
) (
    input  logic [NREG-1:0]          hit,
    input  ctrl_t                    ctrl_q,
    input  logic [DATA_W-SIZE_W-1:0] t0_hi,
    input  logic [DATA_W-SIZE_W-1:0] t1_hi,
    input  logic [SIZE_W:0]          width_q,
    input  logic [SIZE_W:0]          height_q,
    input  logic [DATA_W-1:0]        t2_q,
    input  logic [DATA_W-1:0]        subp_q,
    input  logic                     st_frame,
    input  logic                     st_pal,
    input  logic                     st_sync,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] v_ctrl, v_t0, v_t1, v_t2, v_stat;
    logic [SIZE_W-1:0] wm1, hm1;

    assign wm1 = width_q[SIZE_W-1:0] - SIZE_W'(1);
    assign hm1 = height_q[SIZE_W-1:0] - SIZE_W'(1);

    always_comb begin
        v_ctrl      = ctrl_q.spare | CTRL_RD_ONES;
        v_ctrl[23]  = v_ctrl[23] | ctrl_q.tft;
        v_ctrl[7]   = v_ctrl[7] | ctrl_q.tft;
        v_ctrl[21:20] = v_ctrl[21:20] | ctrl_q.pal;
        v_ctrl[4:3] = v_ctrl[4:3] | ctrl_q.mask;
        v_ctrl[1]   = v_ctrl[1] | ctrl_q.mono;
        v_ctrl[0]   = v_ctrl[0] | ctrl_q.en;
        v_t0        = {t0_hi, wm1} | TIM0_RD_ONES;
        v_t1        = {t1_hi, hm1};
        v_t2        = t2_q | TIM2_RD_ONES;
        v_stat      = '0;
        v_stat[6]   = st_pal;
        v_stat[2]   = st_sync;
        v_stat[0]   = st_frame;
    end

    always_comb begin
        rdata = '0;
        unique case (1'b1)
            hit[IX_CTRL]: rdata = v_ctrl;
            hit[IX_TIM0]: rdata = v_t0;
            hit[IX_TIM1]: rdata = v_t1;
            hit[IX_TIM2]: rdata = v_t2;
            hit[IX_STAT]: rdata = v_stat;
            hit[IX_SUBP]: rdata = subp_q;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bad_access,
    input  logic              evt_frame,
    input  logic              evt_pal,
    input  logic              evt_sync,
    output logic              lcd_en,
    output logic              mono_mode,
    output logic              tft_mode,
    output logic [1:0]        pal_mode,
    output logic [SIZE_W:0]   panel_width,
    output logic [SIZE_W:0]   panel_height,
    output logic              irq
);
    localparam int HI_W = DATA_W - SIZE_W;

    logic [NREG-1:0] hit, wr;
    ctrl_t           ctrl_q;
    logic            en_next;
    logic [1:0]      pal_next;
    logic [HI_W-1:0] t0_hi, t1_hi;
    logic [DATA_W-1:0] t2_q, subp_q;
    logic            st_frame, st_pal, st_sync;
    logic [1:0]      irq_mask;

    lcd_regif_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .hit     (hit),
        .wr      (wr),
        .bad     (bad_access)
    );

    lcd_regif_regs #(.SIZE_W(SIZE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .en_next (en_next),
        .pal_next(pal_next),
        .t0_hi   (t0_hi),
        .t1_hi   (t1_hi),
        .width_q (panel_width),
        .height_q(panel_height),
        .t2_q    (t2_q),
        .subp_q  (subp_q)
    );

    assign irq_mask = ctrl_q.mask;

    lcd_regif_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_next  (en_next),
        .pal_next (pal_next),
        .mask     (irq_mask),
        .evt_frame(evt_frame),
        .evt_pal  (evt_pal),
        .evt_sync (evt_sync),
        .st_frame (st_frame),
        .st_pal   (st_pal),
        .st_sync  (st_sync),
        .irq      (irq)
    );

    lcd_regif_rdmux #(.SIZE_W(SIZE_W)) u_rd (
        .hit     (hit),
        .ctrl_q  (ctrl_q),
        .t0_hi   (t0_hi),
        .t1_hi   (t1_hi),
        .width_q (panel_width),
        .height_q(panel_height),
        .t2_q    (t2_q),
        .subp_q  (subp_q),
        .st_frame(st_frame),
        .st_pal  (st_pal),
        .st_sync (st_sync),
        .rdata   (bus_rdata)
    );

    assign lcd_en    = ctrl_q.en;
    assign mono_mode = ctrl_q.mono;
    assign tft_mode  = ctrl_q.tft;
    assign pal_mode  = ctrl_q.pal;
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lcd_en,
    input logic [1:0]  pal_mode,
    input logic        st_frame,
    input logic        st_pal,
    input logic        st_sync,
    input logic        irq,
    input logic        evt_frame,
    input logic        evt_sync,
    input logic        bad_access,
    input logic [31:0] bus_rdata
);
    p_sync_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_sync |=> irq);

    p_quiet_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_frame && !st_pal && !st_sync) |=> !irq);

    p_stop_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lcd_en) && pal_mode != 2'd1) |-> st_frame);

    p_stop_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lcd_en) && !$past(evt_sync)) |-> !st_sync);

    p_start_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_en) && !$past(evt_frame)) |-> !st_frame);

    p_frame_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_frame) |-> $rose(lcd_en));

    p_bad_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> (bus_rdata == 32'h0));
endmodule

bind lcd_regif lcd_regif_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcd_en    (lcd_en),
    .pal_mode  (pal_mode),
    .st_frame  (st_frame),
    .st_pal    (st_pal),
    .st_sync   (st_sync),
    .irq       (irq),
    .evt_frame (evt_frame),
    .evt_sync  (evt_sync),
    .bad_access(bad_access),
    .bus_rdata (bus_rdata)
);

// File: tb/lcd_regif_tb.sv
`timescale 1ns/1ps
module lcd_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bad_access;
    logic        evt_frame = 1'b0, evt_pal = 1'b0, evt_sync = 1'b0;
    logic        lcd_en, mono_mode, tft_mode, irq;
    logic [1:0]  pal_mode;
    logic [10:0] panel_width, panel_height;

    always #2 clk = ~clk;

    lcd_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bad_access(bad_access), .evt_frame(evt_frame), .evt_pal(evt_pal),
        .evt_sync(evt_sync), .lcd_en(lcd_en), .mono_mode(mono_mode),
        .tft_mode(tft_mode), .pal_mode(pal_mode), .panel_width(panel_width),
        .panel_height(panel_height), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;

    bit m_en, m_mono, m_tft, m_f, m_p, m_s, m_irq;
    bit [1:0]  m_mask, m_pal;
    bit [31:0] m_spare, m_t2, m_sub;
    bit [21:0] m_t0hi, m_t1hi;
    bit [10:0] m_w, m_h;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_bad(input logic [7:0] a);
        return (a[1:0] != 2'b00) || (a > 8'h14);
    endfunction

    function automatic string rtag(input logic [7:0] a);
        case (a)
            8'h00: return "R3 control read";
            8'h04: return "R4 timing0 read";
            8'h08: return "R5 timing1 read";
            8'h0c: return "R6 timing2 read";
            8'h10: return "R8 status read";
            8'h14: return "R7 subpanel read";
            default: return "R12 unmapped read";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] v;
        logic [9:0]  s;
        v = '0;
        if (is_bad(a)) return 32'h0;
        case (a)
            8'h00: begin
                v = m_spare | 32'hfe000c34;
                v[23] |= m_tft; v[7] |= m_tft; v[21:20] |= m_pal;
                v[4:3] |= m_mask; v[1] |= m_mono; v[0] |= m_en;
            end
            8'h04: begin s = m_w[9:0] - 10'd1; v = {m_t0hi, s} | 32'hf; end
            8'h08: begin s = m_h[9:0] - 10'd1; v = {m_t1hi, s}; end
            8'h0c: v = m_t2 | 32'hfc000000;
            8'h10: begin v[6] = m_p; v[2] = m_s; v[0] = m_f; end
            default: v = m_sub;
        endcase
        return v;
    endfunction

    task automatic step(input bit sel, input bit we, input logic [7:0] a,
                        input logic [31:0] d, input bit ef, input bit ep, input bit es);
        bit irq_n, en_old;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
        evt_frame = ef; evt_pal = ep; evt_sync = es;
        #1;
        if (sel && !we) chk(rtag(a), bus_rdata, exp_read(a));
        if (!sel) chk("R12 idle rdata", bus_rdata, 32'h0);
        chk("R12 bad flag", {31'b0, bad_access}, {31'b0, sel && is_bad(a)});
        @(posedge clk);
        irq_n  = (m_f && m_mask[0]) || (m_p && m_mask[1]) || m_s;
        en_old = m_en;
        if (sel && we && !is_bad(a)) begin
            case (a)
                8'h00: begin
                    m_en = d[0]; m_mono = d[1]; m_mask = d[4:3]; m_tft = d[7];
                    m_pal = d[21:20]; m_spare = d & 32'h01cff300;
                end
                8'h04: begin m_t0hi = d[31:10]; m_w = {1'b0, d[9:0]} + 11'd1; end
                8'h08: begin m_t1hi = d[31:10]; m_h = {1'b0, d[9:0]} + 11'd1; end
                8'h0c: m_t2 = d;
                8'h14: m_sub = d & 32'ha1ffffff;
                default: ;
            endcase
        end
        if (!en_old && m_en) begin m_f = 0; m_p = 0; end
        else if (en_old && !m_en) begin m_s = 0; if (m_pal != 2'd1) m_f = 1; end
        m_f |= ef; m_p |= ep; m_s |= es;
        m_irq = irq_n;
        #1;
        chk("R9 irq", {31'b0, irq}, {31'b0, m_irq});
        chk("R2 decoded outputs", {26'b0, lcd_en, mono_mode, tft_mode, pal_mode, 1'b0},
            {26'b0, m_en, m_mono, m_tft, m_pal, 1'b0});
        chk("R4 R5 sizes", {10'b0, panel_width, panel_height}, {10'b0, m_w, m_h});
        bus_sel = 0; bus_we = 0; evt_frame = 0; evt_pal = 0; evt_sync = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        step(1, 0, a, 32'h0, 0, 0, 0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        #7 rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset outputs", {22'b0, lcd_en, mono_mode, tft_mode, pal_mode, irq, panel_width[3:0]}, 32'h0);
        chk("R1 reset sizes", {10'b0, panel_width, panel_height}, 32'h0);
        for (int i = 0; i < 6; i++) rd(8'(i * 4));
        // R2 R3 control decode with tft mirror and spare bits
        wr(8'h00, 32'hffff_ffff & ~32'h1);
        rd(8'h00);
        // R4 size extremes
        wr(8'h04, 32'hdead_b3ff); rd(8'h04);
        wr(8'h04, 32'h0000_0400); rd(8'h04);
        wr(8'h08, 32'h1234_5000); rd(8'h08);
        wr(8'h08, 32'h0000_03ff); rd(8'h08);
        // R6 R7
        wr(8'h0c, 32'h0123_4567); rd(8'h0c);
        wr(8'h14, 32'hffff_ffff); rd(8'h14);
        // R8 status write ignored
        step(1, 0, 8'h00, 0, 0, 1, 0);
        wr(8'h10, 32'hffff_ffff); rd(8'h10);
        // R11 start clears frame/pal
        wr(8'h00, 32'h0000_0001); rd(8'h10);
        // R9 sync interrupts with zero mask
        step(0, 0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 0, 0); rd(8'h10);
        // R10 stop with pal_mode 1: no frame-done, sync cleared
        wr(8'h00, 32'h0010_0000); rd(8'h10);
        // R10 stop with pal_mode 0 and sync event same cycle
        wr(8'h00, 32'h0000_0019);
        step(1, 1, 8'h00, 32'h0000_0018, 0, 0, 1); rd(8'h10);
        // R11 start with coincident frame event
        step(1, 1, 8'h00, 32'h0000_0001, 1, 0, 0); rd(8'h10);
        // R12 unmapped and misaligned writes ignored
        wr(8'h18, 32'hffff_ffff); wr(8'h05, 32'h0); rd(8'h04); rd(8'h18); rd(8'hfc); rd(8'h02);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] a;
            logic [31:0] d;
            bit s, w;
            a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(($urandom % 7) * 4);
            d = $urandom;
            s = ($urandom % 5) != 0;
            w = $urandom % 2;
            step(s, w, a, d, ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 16) == 0);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule